// File: doc/BRIEF.md
# Status Register Read Instruction Unit

This unit decodes and executes the instruction that copies a processor status word into a general-purpose register. It accepts two 32-bit encodings: a conditional word form and a compact form made of two halfwords (first halfword in bits 31:16, second in bits 15:0). One select bit in the instruction chooses between the live status word and the saved status word that belongs to the current mode. The result is a destination register index, a write enable and the data to write, together with flags that report an undefined instruction or an unpredictable encoding.

Before it is returned, the live status word passes through a fixed mask that removes the execution-state and single-step bits. A privilege-access-never enable input keeps one more bit. At the lowest privilege level, the fields that reveal privileged state are forced to zero. A saved-word read from a mode that has no saved copy is resolved either as an undefined instruction or as a no-op, and a parameter picks which. Condition evaluation, the register file and the pipeline are outside this unit. With `OUT_REG=1` (the default) all outputs come from one register stage.

Top module: `psr_rd_unit`

## Requirements
- R1: Word form is recognised when instr_i[27:23]=00010, instr_i[21:20]=00, instr_i[9]=0, instr_i[7:4]=0000 and instr_i[31:28]!=1111 (with enc_compact_i=0). The select bit is instr_i[22] and the destination is instr_i[15:12]. If the form is not recognised, all outputs are zero.
- R2: Compact form is recognised when instr_i[31:21]=11110011111, instr_i[15:14]=10 and instr_i[12]=0 (with enc_compact_i=1). The select bit is instr_i[20] and the destination is instr_i[11:8]. If the form is not recognised, all outputs are zero.
- R3: When the select bit is 1 and the mode allows it, wr_data_o equals saved_psr_i unmodified. When the select bit is 0, the data comes from live_psr_i.
- R4: A live read returns live_psr_i AND 0xF80F03DF. When pan_en_i=1, bit 22 is also passed through.
- R5: A live read with el0_i=1 forces bits 22, 9:6 and 4:0 of the result to zero. A saved read is not scrubbed.
- R6: A destination index of 15 sets unpred_o=1 and wr_en_o=0. wr_data_o is zero whenever wr_en_o is 0.
- R7: A saved read in user mode (mode_i=10000) or system mode (mode_i=11111) gives no write and unpred_o=0. With SAVED_FAULT_UNDEF=1 it sets undef_o=1; with SAVED_FAULT_UNDEF=0 it raises no flag.
- R8: In an otherwise valid write, a mismatch on the should-be-one bits (instr_i[19:16]=1111 in both forms) or on the should-be-zero bits sets unpred_o=1 and the write still happens. The should-be-zero bits are instr_i[11:10], [8] and [3:0] in the word form, and instr_i[13] and [7:0] in the compact form.
- R9: When cond_ok_i=0, wr_en_o, undef_o and unpred_o are 0 and rd_idx_o is 0. For a recognised instruction with cond_ok_i=1, rd_idx_o is the decoded destination.
- R10: With OUT_REG=1 the outputs reflect the inputs of the previous rising clock edge. A synchronous active-high rst clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| enc_compact_i | input | 1 | 1 selects the compact two-halfword form |
| cond_ok_i | input | 1 | Condition check passed |
| mode_i | input | 5 | Current processor mode |
| el0_i | input | 1 | Executing at the lowest privilege level |
| live_psr_i | input | 32 | Current processor status word |
| saved_psr_i | input | 32 | Saved status word of the current mode |
| pan_en_i | input | 1 | Privilege-access-never feature present |
| rd_idx_o | output | 4 | Destination register index |
| wr_en_o | output | 1 | Register write enable |
| wr_data_o | output | 32 | Register write data |
| undef_o | output | 1 | Undefined instruction |
| unpred_o | output | 1 | Unpredictable encoding |

## Verification
The bench targets the following corner cases:
- The extra bit kept by the feature enable: a design that ignored it would return bit 22 as zero.
- Scrubbing at the lowest privilege: a design that scrubbed saved reads too would corrupt bits 22, 9:6 and 4:0 of the saved word.
- Saved reads in user and system modes: a wrong design would still write a register, or raise undef_o in the no-op configuration.
- Destination 15 and stray should-be bits: a design that mixed these up would either drop a valid write or let a write to index 15 through.
- Near-miss encodings, a condition field of 1111 and a failed condition: each of these must leave every output quiet.

// File: rtl/psr_rd_pkg.sv
package psr_rd_pkg;
  localparam int PSR_W = 32;
  localparam int IDX_W = 4;
  localparam int MODE_W = 5;
  localparam logic [PSR_W-1:0] LIVE_KEEP  = 32'hF80F03DF;
  localparam logic [PSR_W-1:0] PAN_KEEP   = 32'h00400000;
  localparam logic [PSR_W-1:0] EL0_SCRUB  = 32'h004003DF;
  localparam logic [MODE_W-1:0] MODE_USR  = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_SYS  = 5'b11111;
  localparam logic [IDX_W-1:0]  IDX_PC    = '1;

  typedef struct packed {
    logic             hit;
    logic             use_saved;
    logic [IDX_W-1:0] rd;
    logic             sb_bad;
  } dec_t;
endpackage

// File: rtl/psr_rd_dec_word.sv
module psr_rd_dec_word
  import psr_rd_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic fixed_ok, cond_ok;
  always_comb begin
    fixed_ok = (instr[27:23] == 5'b00010) && (instr[21:20] == 2'b00) &&
               (instr[9] == 1'b0) && (instr[7:4] == 4'b0000);
    cond_ok  = (instr[31:28] != 4'hF);
    dec.hit       = fixed_ok && cond_ok;
    dec.use_saved = instr[22];
    dec.rd        = instr[15:12];
    dec.sb_bad    = (instr[19:16] != 4'hF) || (instr[11:10] != 2'b00) ||
                    instr[8] || (instr[3:0] != 4'h0);
  end
endmodule

// File: rtl/psr_rd_dec_compact.sv
module psr_rd_dec_compact
  import psr_rd_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic [15:0] hw_a, hw_b;
  always_comb begin
    hw_a = instr[31:16];
    hw_b = instr[15:0];
    dec.hit       = (hw_a[15:5] == 11'b11110011111) &&
                    (hw_b[15:14] == 2'b10) && (hw_b[12] == 1'b0);
    dec.use_saved = hw_a[4];
    dec.rd        = hw_b[11:8];
    dec.sb_bad    = (hw_a[3:0] != 4'hF) || hw_b[13] || (hw_b[7:0] != 8'h00);
  end
endmodule

// File: rtl/psr_rd_filter.sv
module psr_rd_filter
  import psr_rd_pkg::*;
(
  input  logic [PSR_W-1:0] live_psr,
  input  logic [PSR_W-1:0] saved_psr,
  input  logic             use_saved,
  input  logic             pan_en,
  input  logic             el0,
  output logic [PSR_W-1:0] value
);
  logic [PSR_W-1:0] keep, live_v;
  always_comb begin
    keep   = LIVE_KEEP | (pan_en ? PAN_KEEP : '0);
    live_v = live_psr & keep;
    if (el0) live_v = live_v & ~EL0_SCRUB;
    value  = use_saved ? saved_psr : live_v;
  end
endmodule

// File: rtl/psr_rd_unit.sv
module psr_rd_unit
  import psr_rd_pkg::*;
#(
  parameter bit OUT_REG           = 1'b1,
  parameter bit SAVED_FAULT_UNDEF = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       instr_i,
  input  logic              enc_compact_i,
  input  logic              cond_ok_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              el0_i,
  input  logic [PSR_W-1:0]  live_psr_i,
  input  logic [PSR_W-1:0]  saved_psr_i,
  input  logic              pan_en_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              wr_en_o,
  output logic [PSR_W-1:0]  wr_data_o,
  output logic              undef_o,
  output logic              unpred_o
);
  dec_t dec_w, dec_c, dec;
  logic [PSR_W-1:0] val;
  logic active, no_saved;
  logic [IDX_W-1:0] n_rd;
  logic n_we, n_undef, n_unpred;
  logic [PSR_W-1:0] n_data;

  psr_rd_dec_word    u_dec_w (.instr(instr_i), .dec(dec_w));
  psr_rd_dec_compact u_dec_c (.instr(instr_i), .dec(dec_c));

  assign dec = enc_compact_i ? dec_c : dec_w;

  psr_rd_filter u_filt (
    .live_psr (live_psr_i),
    .saved_psr(saved_psr_i),
    .use_saved(dec.use_saved),
    .pan_en   (pan_en_i),
    .el0      (el0_i),
    .value    (val)
  );

  always_comb begin
    active   = dec.hit && cond_ok_i;
    no_saved = dec.use_saved && ((mode_i == MODE_USR) || (mode_i == MODE_SYS));
    n_rd     = active ? dec.rd : '0;
    n_we     = active && !no_saved && (dec.rd != IDX_PC);
    n_undef  = active && no_saved && SAVED_FAULT_UNDEF;
    n_unpred = active && !no_saved && ((dec.rd == IDX_PC) || dec.sb_bad);
    n_data   = n_we ? val : '0;
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          rd_idx_o  <= '0;
          wr_en_o   <= 1'b0;
          wr_data_o <= '0;
          undef_o   <= 1'b0;
          unpred_o  <= 1'b0;
        end else begin
          rd_idx_o  <= n_rd;
          wr_en_o   <= n_we;
          wr_data_o <= n_data;
          undef_o   <= n_undef;
          unpred_o  <= n_unpred;
        end
      end
    end else begin : g_comb
      assign rd_idx_o  = n_rd;
      assign wr_en_o   = n_we;
      assign wr_data_o = n_data;
      assign undef_o   = n_undef;
      assign unpred_o  = n_unpred;
    end
  endgenerate
endmodule

// File: rtl/psr_rd_unit_chk.sv
module psr_rd_unit_chk
  import psr_rd_pkg::*;
#(
  parameter bit OUT_REG           = 1'b1,
  parameter bit SAVED_FAULT_UNDEF = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             cond_ok_i,
  input logic [IDX_W-1:0] rd_idx_o,
  input logic             wr_en_o,
  input logic [PSR_W-1:0] wr_data_o,
  input logic             undef_o,
  input logic             unpred_o
);
  a_r6_no_pc_write: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (rd_idx_o != IDX_PC));

  a_r6_quiet_data: assert property (@(posedge clk) disable iff (rst)
    !wr_en_o |-> (wr_data_o == '0));

  a_r7_undef_alone: assert property (@(posedge clk) disable iff (rst)
    undef_o |-> (!wr_en_o && !unpred_o));

  a_r7_nop_config: assert property (@(posedge clk) disable iff (rst)
    undef_o |-> SAVED_FAULT_UNDEF);

  generate
    if (OUT_REG) begin : g_seq
      a_r9_cond_gate: assert property (@(posedge clk) disable iff (rst)
        !$past(cond_ok_i) |-> (!wr_en_o && !undef_o && !unpred_o && rd_idx_o == '0));
      a_r10_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!wr_en_o && !undef_o && !unpred_o));
    end else begin : g_cmb
      a_r9_cond_gate: assert property (@(posedge clk) disable iff (rst)
        !cond_ok_i |-> (!wr_en_o && !undef_o && !unpred_o && rd_idx_o == '0));
    end
  endgenerate
endmodule

bind psr_rd_unit psr_rd_unit_chk #(
  .OUT_REG(OUT_REG), .SAVED_FAULT_UNDEF(SAVED_FAULT_UNDEF)
) u_chk (
  .clk(clk), .rst(rst), .cond_ok_i(cond_ok_i), .rd_idx_o(rd_idx_o),
  .wr_en_o(wr_en_o), .wr_data_o(wr_data_o), .undef_o(undef_o), .unpred_o(unpred_o)
);

// File: tb/tb_psr_rd_unit.sv
module tb_psr_rd_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] instr = '0;
  logic comp = 1'b0, cok = 1'b0, el0 = 1'b0, pan = 1'b0;
  logic [4:0] mode = 5'b10011;
  logic [31:0] live = '0, saved = '0;
  logic [3:0] rd_a, rd_b;
  logic we_a, we_b, ud_a, ud_b, up_a, up_b;
  logic [31:0] d_a, d_b;
  int n_tests = 0, n_fail = 0;
  bit pending = 0;
  string ptag;
  logic [38:0] exp_a, exp_b;

  always #10 clk = ~clk;

  psr_rd_unit #(.OUT_REG(1'b1), .SAVED_FAULT_UNDEF(1'b1)) dut (
    .clk(clk), .rst(rst), .instr_i(instr), .enc_compact_i(comp), .cond_ok_i(cok),
    .mode_i(mode), .el0_i(el0), .live_psr_i(live), .saved_psr_i(saved), .pan_en_i(pan),
    .rd_idx_o(rd_a), .wr_en_o(we_a), .wr_data_o(d_a), .undef_o(ud_a), .unpred_o(up_a));

  psr_rd_unit #(.OUT_REG(1'b1), .SAVED_FAULT_UNDEF(1'b0)) dut_nop (
    .clk(clk), .rst(rst), .instr_i(instr), .enc_compact_i(comp), .cond_ok_i(cok),
    .mode_i(mode), .el0_i(el0), .live_psr_i(live), .saved_psr_i(saved), .pan_en_i(pan),
    .rd_idx_o(rd_b), .wr_en_o(we_b), .wr_data_o(d_b), .undef_o(ud_b), .unpred_o(up_b));

  // Reference: {rd[3:0], we, data[31:0], undef, unpred}
  function automatic logic [38:0] model(input logic [31:0] i, input logic c,
      input logic ok, input logic [4:0] m, input logic e0, input logic [31:0] lv,
      input logic [31:0] sv, input logic pn, input bit trap_undef);
    bit hit, sel, odd;
    int rd;
    logic [31:0] v;
    if (c) begin
      hit = ((i & 32'hFFE0D000) == 32'hF3E08000);
      sel = i[20]; rd = int'(i[11:8]);
      odd = ((i & 32'h000F0000) != 32'h000F0000) || ((i & 32'h000020FF) != 0);
    end else begin
      hit = ((i & 32'h0FB002F0) == 32'h01000000) && (i[31:28] != 4'hF);
      sel = i[22]; rd = int'(i[15:12]);
      odd = ((i & 32'h000F0000) != 32'h000F0000) || ((i & 32'h00000D0F) != 0);
    end
    if (!(hit && ok)) return '0;
    if (sel && (m == 5'b10000 || m == 5'b11111))
      return {rd[3:0], 1'b0, 32'h0, trap_undef, 1'b0};
    if (rd == 15) return {4'hF, 1'b0, 32'h0, 1'b0, 1'b1};
    if (sel) v = sv;
    else begin
      v = lv & 32'hF80F03DF;
      if (pn) v[22] = lv[22];
      if (e0) begin v[22] = 1'b0; v[9:6] = 4'h0; v[4:0] = 5'h0; end
    end
    return {rd[3:0], 1'b1, v, 1'b0, odd};
  endfunction

  function automatic logic [31:0] wenc(input logic [3:0] cnd, input logic r, input logic [3:0] d);
    return {cnd, 5'b00010, r, 2'b00, 4'hF, d, 2'b00, 1'b0, 1'b0, 4'h0, 4'h0};
  endfunction
  function automatic logic [31:0] cenc(input logic r, input logic [3:0] d);
    return {11'b11110011111, r, 4'hF, 2'b10, 1'b0, 1'b0, d, 8'h00};
  endfunction

  task automatic cmp_one(input string nm, input logic [38:0] act, input logic [38:0] ex);
    n_tests++;
    if (act !== ex) begin
      n_fail++;
      $display("FAIL %s [%s] actual rd=%h we=%b d=%h ud=%b up=%b expected rd=%h we=%b d=%h ud=%b up=%b",
        ptag, nm, act[38:35], act[34], act[33:2], act[1], act[0],
        ex[38:35], ex[34], ex[33:2], ex[1], ex[0]);
    end
  endtask

  task automatic check_pending();
    if (pending) begin
      cmp_one("undef-cfg", {rd_a, we_a, d_a, ud_a, up_a}, exp_a);
      cmp_one("nop-cfg",   {rd_b, we_b, d_b, ud_b, up_b}, exp_b);
    end
  endtask

  // Called on a negedge: checks the previous vector, then applies a new one.
  task automatic apply(input logic [31:0] i, input logic c, input logic ok, input logic [4:0] m,
      input logic e0, input logic [31:0] lv, input logic [31:0] sv, input logic pn, input string tag);
    @(negedge clk);
    check_pending();
    instr = i; comp = c; cok = ok; mode = m; el0 = e0; live = lv; saved = sv; pan = pn;
    exp_a = model(i, c, ok, m, e0, lv, sv, pn, 1'b1);
    exp_b = model(i, c, ok, m, e0, lv, sv, pn, 1'b0);
    ptag = tag; pending = 1;
  endtask

  initial begin
    #(20 * 5000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R10: reset state, with a valid instruction on the inputs
    instr = wenc(4'h0, 1'b0, 4'd2); cok = 1'b1; live = '1;
    repeat (3) @(negedge clk);
    ptag = "R10 reset";
    cmp_one("undef-cfg", {rd_a, we_a, d_a, ud_a, up_a}, 39'h0);
    cmp_one("nop-cfg",   {rd_b, we_b, d_b, ud_b, up_b}, 39'h0);
    rst = 1'b0;
    apply(wenc(4'hE, 0, 4'd3), 0, 1, 5'b10011, 0, 32'hFFFFFFFF, 32'h0, 0, "R1 R4 word live mask");
    apply(wenc(4'hE, 0, 4'd3), 0, 1, 5'b10011, 0, 32'hFFFFFFFF, 32'h0, 1, "R4 pan keeps bit22");
    apply(wenc(4'h1, 0, 4'd4), 0, 1, 5'b10000, 1, 32'hFFFFFFFF, 32'h0, 1, "R5 el0 scrub");
    apply(wenc(4'h2, 1, 4'd5), 0, 1, 5'b10010, 1, 32'h0, 32'hFFFFFFFF, 1, "R3 R5 saved not scrubbed");
    apply(wenc(4'h0, 1, 4'd6), 0, 1, 5'b10011, 0, 32'hAAAAAAAA, 32'h12345678, 0, "R3 word saved");
    apply(cenc(0, 4'd7), 1, 1, 5'b10011, 0, 32'h5A5A5A5A, 32'h0, 0, "R2 compact live");
    apply(cenc(1, 4'd12), 1, 1, 5'b11011, 0, 32'h0, 32'hCAFEF00D, 0, "R2 R3 compact saved");
    apply(wenc(4'hE, 0, 4'd15), 0, 1, 5'b10011, 0, 32'hFFFFFFFF, 32'h0, 0, "R6 word rd15");
    apply(cenc(0, 4'd15), 1, 1, 5'b10011, 0, 32'hFFFFFFFF, 32'h0, 0, "R6 compact rd15");
    apply(wenc(4'hE, 1, 4'd1), 0, 1, 5'b10000, 1, 32'h0, 32'hFFFFFFFF, 0, "R7 saved in user");
    apply(cenc(1, 4'd2), 1, 1, 5'b11111, 0, 32'h0, 32'hFFFFFFFF, 0, "R7 saved in system");
    apply(wenc(4'hE, 0, 4'd3), 0, 0, 5'b10011, 0, 32'hFFFFFFFF, 32'h0, 0, "R9 cond fail");
    apply(wenc(4'hF, 0, 4'd3), 0, 1, 5'b10011, 0, 32'hFFFFFFFF, 32'h0, 0, "R1 cond field 1111");
    apply(wenc(4'hE, 0, 4'd3) | 32'h1, 0, 1, 5'b10011, 0, 32'hFFFFFFFF, 32'h0, 0, "R8 word sbz set");
    apply(wenc(4'hE, 0, 4'd3) & ~32'h00010000, 0, 1, 5'b10011, 0, 32'hF, 32'h0, 0, "R8 word sbo clear");
    apply(cenc(0, 4'd9) & ~32'h00040000, 1, 1, 5'b10011, 0, 32'hFFFF, 32'h0, 0, "R8 compact sbo clear");
    apply(cenc(0, 4'd9) | 32'h2000, 1, 1, 5'b10011, 0, 32'hFFFF, 32'h0, 0, "R8 compact sbz set");
    apply(cenc(0, 4'd9) | 32'h1000, 1, 1, 5'b10011, 0, 32'hFFFF, 32'h0, 0, "R2 compact fixed miss");
    apply(wenc(4'hE, 0, 4'd3) | 32'h200, 0, 1, 5'b10011, 0, 32'hFFFF, 32'h0, 0, "R1 word fixed miss");
    apply(wenc(4'hE, 0, 4'd3), 1, 1, 5'b10011, 0, 32'hFFFF, 32'h0, 0, "R2 word bits as compact");
    for (int k = 0; k < 300; k++) begin
      logic [31:0] base;
      logic c;
      c = 1'($urandom_range(0, 1));
      base = c ? cenc(1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)))
               : wenc(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
      if ($urandom_range(0, 7) == 0) base = base ^ (32'h1 << $urandom_range(0, 31));
      apply(base, c, ($urandom_range(0, 5) != 0),
            ($urandom_range(0, 2) == 0) ? 5'b10000 : (($urandom_range(0, 1) == 0) ? 5'b11111 : 5'b10011),
            1'($urandom_range(0, 1)), $urandom, $urandom, 1'($urandom_range(0, 1)),
            "R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    // R10: the last vector settles one edge later
    @(negedge clk);
    check_pending();
    pending = 0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule